// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache Controller

This block sits between a processor's load/store port and a slower main memory. It keeps a small direct-mapped store of four lines, each two 32-bit words (8 bytes) wide. Every request address is divided into three fields: a byte offset, a line index and a tag. The tag is compared against the entry that the index selects. A load that hits is answered in the same cycle it is presented. A load that misses fetches the whole line from memory one word per beat, installs it under the new tag, and then answers.

Stores go through to memory every time. If the addressed line is already present, its cached word is also updated. If it is not present, nothing is fetched and no line is allocated. The processor holds its request steady until `cpu_ready` is high at a rising clock edge; that edge completes the transfer.

Top module: `cache_dm_ctrl`

## Requirements
- R1: After reset every line is invalid and no memory request is active, so the first load to any index misses and starts a line fetch.
- R2: Address bits [1:0] are ignored. Bit [2] selects the word within a line. Bits [4:3] select one of the four lines. Bits [31:5] form the tag.
- R3: A load whose tag matches a valid line raises `cpu_ready` in the same cycle with the cached word on `cpu_rdata`, and issues no memory request.
- R4: On a load miss, `mem_rd_req` rises one cycle after the request. It stays high until the last beat is received, with `mem_addr` equal to the line base (bits [2:0] zero). The memory returns word 0 then word 1, each marked by `mem_rd_valid`. `cpu_ready` stays low throughout the fetch.
- R5: In the cycle after the last fill beat, `cpu_ready` is high and `cpu_rdata` carries the requested word. The line then hits, so a miss to a memory that waits L cycles before its first beat completes L+4 cycles after the request.
- R6: A miss at an index that holds a different tag replaces that line. After address 1008 is loaded, address 1040 (also index 2) misses again.
- R7: A store raises `mem_wr_req` one cycle after the request, with `mem_addr` set to the word address and `mem_wr_data` set to the store data. `cpu_ready` is high only in the cycle that `mem_wr_ack` is high. No line fetch is issued.
- R8: A store that hits also updates the cached word, so a later load hits and returns the new value.
- R9: A store that misses allocates nothing. The line previously held at that index still hits, and a later load of the stored address misses and returns the written value from memory.
- R10: A store hit leaves the other word of the same line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is high on a load |
| cpu_ready | output | 1 | Transfer completes at this clock edge |
| mem_addr | output | 32 | Line base during a fetch, word address during a store |
| mem_rd_req | output | 1 | Line fetch request, held for the whole fetch |
| mem_rd_valid | input | 1 | One fill word is present on mem_rd_data |
| mem_rd_data | input | 32 | Fill word, delivered in ascending word order |
| mem_wr_req | output | 1 | Word write request, held until acknowledged |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_ack | input | 1 | Memory has accepted the write |

## Verification
A load hit is due in the request cycle itself. A load miss against a memory with first-beat delay L is due L+4 cycles after the request. A store against a memory with acknowledge delay W is due W+2 cycles after the request. The bench drives each request just after a rising edge and samples at every following falling edge. It counts falling edges until `cpu_ready` appears and compares that count exactly with the expected number. At the completing edge it checks the data, the address and the memory traffic seen so far.

// File: rtl/cache_pkg.sv
// Shared type for the cache controller: the states of the miss/store sequencer.
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REFILL  = 2'd1,
        ST_RESPOND = 2'd2,
        ST_WRITE   = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/cache_addr_split.sv
// Splits a byte address into tag, line index and word-in-line fields.
// Assumes words are BYTE_W-bit aligned; the lowest BYTE_W bits are dropped.
module cache_addr_split #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 1,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = ADDR_W - BYTE_W - WSEL_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] word
);
    localparam int IDX_LO = BYTE_W + WSEL_W;
    localparam int TAG_LO = IDX_LO + IDX_W;

    // field extraction
    always_comb begin
        word = addr[BYTE_W +: WSEL_W];
        idx  = addr[IDX_LO +: IDX_W];
        tag  = addr[TAG_LO +: TAG_W];
    end
endmodule

// File: rtl/cache_line_store.sv
// Tag, valid and data arrays for a direct-mapped cache.
// One read port (combinational) and two write ports: one word write
// and one tag write that also sets the valid bit. Valid bits clear on reset;
// tags and data are not reset.
module cache_line_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 2,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 27,
    parameter int IDX_W  = $clog2(LINES),
    parameter int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_en,
    input  logic [IDX_W-1:0]  tag_idx,
    input  logic [TAG_W-1:0]  tag_val
);
    localparam int CELLS = LINES * WORDS;

    logic [LINES-1:0]        valid_vec;
    logic [LINES*TAG_W-1:0]  tag_flat;
    logic [CELLS*DATA_W-1:0] data_flat;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic             valid_q;
        logic [TAG_W-1:0] tag_q;

        // line valid flag and tag capture
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
            end else if (tag_en && tag_idx == IDX_W'(l)) begin
                valid_q <= 1'b1;
                tag_q   <= tag_val;
            end
        end

        assign valid_vec[l]                  = valid_q;
        assign tag_flat[l*TAG_W +: TAG_W]    = tag_q;

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            logic [DATA_W-1:0] word_q;

            // one data word of this line
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(l) && wr_word == WSEL_W'(w)) begin
                    word_q <= wr_data;
                end
            end

            assign data_flat[(l*WORDS + w)*DATA_W +: DATA_W] = word_q;
        end
    end

    // lookup read port
    always_comb begin
        rd_valid = valid_vec[rd_idx];
        rd_tag   = tag_flat[int'(rd_idx)*TAG_W +: TAG_W];
        rd_data  = data_flat[(int'(rd_idx)*WORDS + int'(rd_word))*DATA_W +: DATA_W];
    end

    AST_VALID_CLEAR_ON_RESET: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0)); // R1

    AST_TAG_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tag_en |=> valid_vec[$past(tag_idx)]); // R5
endmodule

// File: rtl/cache_ctrl_fsm.sv
// Sequencer for load misses and write-through stores.
// IDLE answers load hits directly; a load miss goes to REFILL, counts
// WORDS fill beats, then RESPOND for one cycle; a store goes to WRITE and
// waits for the memory acknowledge. Assumes the requester holds its
// request stable until ready, and the memory delivers fill words in order.
module cache_ctrl_fsm
    import cache_pkg::*;
#(
    parameter int WORDS  = 2,
    parameter int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              mem_rd_valid,
    input  logic              mem_wr_ack,
    output ctrl_state_t       state,
    output logic [WSEL_W-1:0] beat,
    output logic              fill_we,
    output logic              fill_last,
    output logic              store_we,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic              mem_wr_req
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    ctrl_state_t state_q, state_d;
    logic [WSEL_W-1:0] beat_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we)      state_d = ST_WRITE;
                else if (cpu_req && !hit)   state_d = ST_REFILL;
            end
            ST_REFILL:  if (mem_rd_valid && beat_q == LAST_BEAT) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            ST_WRITE:   if (mem_wr_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state and fill beat registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_REFILL)  beat_q <= '0;
            else if (mem_rd_valid)     beat_q <= beat_q + 1'b1;
        end
    end

    // output decode
    always_comb begin
        state      = state_q;
        beat       = beat_q;
        mem_rd_req = (state_q == ST_REFILL);
        mem_wr_req = (state_q == ST_WRITE);
        fill_we    = mem_rd_req && mem_rd_valid;
        fill_last  = fill_we && (beat_q == LAST_BEAT);
        store_we   = mem_wr_req && mem_wr_ack && hit;
        cpu_ready  = (state_q == ST_IDLE && cpu_req && !cpu_we && hit)
                   || (state_q == ST_RESPOND)
                   || (mem_wr_req && mem_wr_ack);
    end

    AST_REFILL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !fill_last) |=> mem_rd_req); // R4

    AST_NOT_READY_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !cpu_ready); // R4

    AST_RESPOND_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESPOND) |-> hit); // R5

    AST_STORE_READY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> mem_wr_ack); // R7

    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_req, mem_wr_req})); // R7

    AST_STORE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_we) |=> !mem_rd_req); // R9
endmodule

// File: rtl/cache_dm_ctrl.sv
// Direct-mapped, write-through, no-write-allocate data cache controller.
// Load hits complete in the request cycle; load misses fetch a whole line
// one word per beat; every store is written to memory and updates the
// cache only when the line is present. Assumes word-aligned accesses.
module cache_dm_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 2,
    parameter int LINES      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic [DATA_W-1:0] line_word;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid;
    logic              hit;
    ctrl_state_t       state;
    logic [WSEL_W-1:0] beat;
    logic              fill_we, fill_last, store_we;
    logic              arr_we;
    logic [WSEL_W-1:0] arr_word;
    logic [DATA_W-1:0] arr_data;

    cache_addr_split #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .WSEL_W (WSEL_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_split (
        .addr (cpu_addr),
        .tag  (req_tag),
        .idx  (req_idx),
        .word (req_word)
    );

    cache_line_store #(
        .LINES  (LINES),
        .WORDS  (LINE_WORDS),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_word  (req_word),
        .rd_data  (line_word),
        .rd_tag   (line_tag),
        .rd_valid (line_valid),
        .wr_en    (arr_we),
        .wr_idx   (req_idx),
        .wr_word  (arr_word),
        .wr_data  (arr_data),
        .tag_en   (fill_last),
        .tag_idx  (req_idx),
        .tag_val  (req_tag)
    );

    cache_ctrl_fsm #(
        .WORDS  (LINE_WORDS),
        .WSEL_W (WSEL_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_ack   (mem_wr_ack),
        .state        (state),
        .beat         (beat),
        .fill_we      (fill_we),
        .fill_last    (fill_last),
        .store_we     (store_we),
        .cpu_ready    (cpu_ready),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_req   (mem_wr_req)
    );

    // tag compare and array write steering
    always_comb begin
        hit      = line_valid && (line_tag == req_tag);
        arr_we   = fill_we || store_we;
        arr_word = fill_we ? beat : req_word;
        arr_data = fill_we ? mem_rd_data : cpu_wdata;
    end

    // outward data and address
    always_comb begin
        cpu_rdata   = line_word;
        mem_wr_data = cpu_wdata;
        if (state == ST_WRITE)
            mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        else
            mem_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    AST_FETCH_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_addr[OFF_W-1:0] == '0 && $stable(mem_addr))); // R4

    AST_LOAD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_ready) |=> !mem_rd_req && !mem_wr_req); // R3
endmodule

// File: tb/tb_cache_dm_ctrl.sv
module tb_cache_dm_ctrl;
    localparam int RD_LAT = 3;
    localparam int WR_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata, mem_addr, mem_wr_data;
    logic        cpu_ready, mem_rd_req, mem_wr_req;
    logic        mem_rd_valid, mem_wr_ack;
    logic [31:0] mem_rd_data;

    int checks = 0;
    int fails  = 0;
    int rd_starts = 0;
    logic rd_prev;

    always #5 clk = ~clk;

    cache_dm_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_addr(mem_addr), .mem_rd_req(mem_rd_req),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    // slow memory model
    logic [31:0] mem [1024];
    int rd_wait, wr_wait, rd_beat;
    logic rd_done, wr_done;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A00_0000 ^ (a * 32'd7);
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0; mem_wr_ack <= 1'b0; mem_rd_data <= '0;
            rd_wait <= 0; wr_wait <= 0; rd_beat <= 0;
            rd_done <= 1'b0; wr_done <= 1'b0;
            rd_prev <= 1'b0;
        end else begin
            rd_prev <= mem_rd_req;
            if (mem_rd_req && !rd_prev) rd_starts <= rd_starts + 1;
            mem_rd_valid <= 1'b0;
            mem_wr_ack   <= 1'b0;
            if (!mem_rd_req) begin
                rd_wait <= 0; rd_beat <= 0; rd_done <= 1'b0;
            end else if (!rd_done) begin
                if (rd_wait < RD_LAT) rd_wait <= rd_wait + 1;
                else begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= mem[mem_addr[11:2] + 10'(rd_beat)];
                    rd_beat      <= rd_beat + 1;
                    if (rd_beat == 1) rd_done <= 1'b1;
                end
            end
            if (!mem_wr_req) begin
                wr_wait <= 0; wr_done <= 1'b0;
            end else if (!wr_done) begin
                if (wr_wait < WR_LAT) wr_wait <= wr_wait + 1;
                else begin
                    mem_wr_ack <= 1'b1;
                    mem[mem_addr[11:2]] <= mem_wr_data;
                    wr_done <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // load: exp_hit picks the expected completion cycle
    task automatic do_read(input logic [31:0] a, input logic [31:0] exp, input bit exp_hit, input string req);
        int s0, cyc;
        bit addr_seen;
        s0 = rd_starts; cyc = 0; addr_seen = 0;
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (mem_rd_req && !addr_seen) begin
                addr_seen = 1;
                chk(mem_addr == {a[31:3], 3'b000}, "R4 fetch base", mem_addr, {a[31:3], 3'b000});
            end
            if (cpu_ready) break;
            cyc++;
        end
        chk(cyc == (exp_hit ? 0 : RD_LAT + 4), {req, " latency"}, 32'(cyc), 32'(exp_hit ? 0 : RD_LAT + 4));
        chk(cpu_rdata == exp, {req, " data"}, cpu_rdata, exp);
        chk(rd_starts - s0 == (exp_hit ? 0 : 1), {req, " fetch count"}, 32'(rd_starts - s0), 32'(exp_hit ? 0 : 1));
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
        int s0, cyc;
        s0 = rd_starts; cyc = 0;
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (cpu_ready) break;
            cyc++;
        end
        chk(cyc == WR_LAT + 2, {req, " R7 latency"}, 32'(cyc), 32'(WR_LAT + 2));
        chk(mem_wr_req && mem_wr_ack, {req, " R7 ack"}, {30'd0, mem_wr_req, mem_wr_ack}, 32'd3);
        chk(mem_addr == {a[31:2], 2'b00}, {req, " R7 addr"}, mem_addr, {a[31:2], 2'b00});
        chk(mem_wr_data == d, {req, " R7 data"}, mem_wr_data, d);
        chk(rd_starts == s0, {req, " R7 no fetch"}, 32'(rd_starts - s0), 32'd0);
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 idle after reset",
            {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
    endtask

    task automatic t_fill_and_hit();
        do_read(32'd1000, pat(32'd1000), 0, "R1 first load misses");
        do_read(32'd1004, pat(32'd1004), 1, "R3 other word hits");
        do_read(32'd1000, pat(32'd1000), 1, "R5 filled line hits");
        do_read(32'd1006, pat(32'd1004), 1, "R2 low bits ignored");
    endtask

    task automatic t_conflict();
        do_read(32'd1040, pat(32'd1040), 0, "R2 index 2 miss");
        do_read(32'd1008, pat(32'd1008), 0, "R6 conflicting tag miss");
        do_read(32'd1012, pat(32'd1012), 1, "R6 new line hits");
        do_read(32'd1040, pat(32'd1040), 0, "R6 evicted line misses");
    endtask

    task automatic t_store_hit();
        do_write(32'd1040, 32'hDEAD_BEEF, "R8 store hit");
        do_read(32'd1040, 32'hDEAD_BEEF, 1, "R8 updated word hits");
        do_read(32'd1044, pat(32'd1044), 1, "R10 neighbour word kept");
    endtask

    task automatic t_store_miss();
        do_write(32'd1100, 32'h1234_5678, "R9 store miss");
        do_read(32'd1000, pat(32'd1000), 1, "R9 resident line kept");
        do_read(32'd1100, 32'h1234_5678, 0, "R9 no allocate");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill_and_hit();
        t_conflict();
        t_store_hit();
        t_store_miss();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule